// File: doc/BRIEF.md
# Return-to-Zero Pulse Bit Serializer

This block sends a fixed-length run of bytes on one output line as a clockless pulse train. Every bit takes one bit cell of a fixed number of clock cycles. A one bit drives the line high for a short window at the start of its cell and then low for the rest of the cell. A zero bit keeps the line low for the whole cell. The receiver has no clock line, so it recovers the bits only from the cell cadence. For that reason the cell length is exact in clock cycles and never drifts, including across byte boundaries and over thousands of cells.

A `start` pulse while idle opens a transfer. Payload bytes then arrive on a ready/valid input through a one-byte holding register. The first cell begins as soon as the first byte is held. Later bytes are picked up exactly at the cell boundary after the last bit of the previous byte. After the payload the block appends check bytes. Each check byte is a running XOR over an interleaved subset of the payload. When the last check cell ends, `done` pulses for one cycle and `busy` falls.

With the default parameters the block targets a 72 MHz clock: a 288-cycle cell, a 72-cycle high window, 402 payload bytes and two check bytes.

Top module: `rz_pulse_serializer`

## Requirements
- R1: Bit cells are exactly CELL_CYCLES clock cycles long and follow each other with no gap, both inside a byte and across byte boundaries, for the whole transfer.
- R2: In a cell carrying a one, `line_out` is high for exactly the first HIGH_CYCLES cycles and low for the rest of the cell. In a cell carrying a zero, `line_out` is low for the whole cell.
- R3: Each byte is sent most significant bit first: bit DATA_W-1 goes in the first cell of the byte and bit 0 in the last.
- R4: After NUM_BYTES payload bytes, CHECK_LANES check bytes are sent in lane order 0 first. Check lane l is the XOR of every payload byte whose index i (first payload byte is index 0) satisfies i mod CHECK_LANES = l. The check lanes are cleared when a transfer starts.
- R5: A `start` while idle raises `busy` in the next cycle. `in_ready` is high only while busy, the holding register is empty and a payload slot is still unfilled. The first cell begins on the second rising edge after the first byte is accepted.
- R6: If the holding register is empty when a payload slot begins, that byte is sent as all-zero cells at the normal cadence. `underrun` rises at that cell boundary and stays high until the next accepted `start`.
- R7: On the rising edge that ends the last check-byte cell, `done` goes high for exactly one cycle and `busy` goes low in the same cycle.
- R8: A `start` while busy has no effect on the transfer in progress.
- R9: After reset, `line_out`, `busy`, `done`, `in_ready` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transfer when idle |
| in_data | input | DATA_W | Payload byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | The holding register can take a byte |
| line_out | output | 1 | Registered return-to-zero pulse line |
| busy | output | 1 | A transfer is open |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| underrun | output | 1 | Sticky flag: a payload slot went out empty |

## Verification
The hardest case to reach from the ports is a payload slot that begins while the holding register is empty. The producer has a full byte period of slack, so random gaps almost never cause it. The bench forces it by feeding only the first two bytes of a transfer. It then checks that `underrun` is low in the last cycle of the second byte and high in the first cycle of the third. It also checks that the remaining payload and the check bytes go out as the zero-filled stream predicts, with the cadence unchanged. A `start` pulse during a busy transfer and a fresh transfer after an underrun cover the ignore and clear rules.

// File: rtl/rz_pkg.sv
`timescale 1ns/1ps
package rz_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } rz_state_e;
endpackage

// File: rtl/rz_cell_timer.sv
`timescale 1ns/1ps
module rz_cell_timer #(
   parameter int CELL_CYCLES = 288,
   parameter int HIGH_CYCLES = 72,
   localparam int CW = $clog2(CELL_CYCLES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          run,
   output logic [CW-1:0] cnt,
   output logic          cell_last,
   output logic          win_last
);
   if (HIGH_CYCLES < 1 || HIGH_CYCLES >= CELL_CYCLES) begin : g_bad_window
      $error("HIGH_CYCLES must lie in 1..CELL_CYCLES-1");
   end

   assign cell_last = run && (cnt == CW'(CELL_CYCLES - 1));
   assign win_last  = run && (cnt == CW'(HIGH_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (restart)   cnt <= '0;
      else if (run)       cnt <= cell_last ? '0 : cnt + CW'(1);
   end

   // R1: the cell counter never leaves its range
   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CELL_CYCLES - 1));
   // R1: inside a cell the count advances by exactly one each cycle
   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cell_last && !restart) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/rz_check_gen.sv
`timescale 1ns/1ps
module rz_check_gen #(
   parameter int DATA_W = 8,
   parameter int LANES  = 2,
   localparam int LPW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          upd,
   input  logic [DATA_W-1:0]             din,
   output logic [LANES-1:0][DATA_W-1:0]  chk
);
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [LPW-1:0] ptr;

   if (LANES == 1) begin : g_single
      assign ptr = '0;
   end else begin : g_rotate
      logic [LPW-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ptr_q <= '0;
         else if (clr)  ptr_q <= '0;
         else if (upd)  ptr_q <= (ptr_q == LPW'(LANES - 1)) ? '0 : ptr_q + LPW'(1);
      end
      assign ptr = ptr_q;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DATA_W-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           acc_q <= '0;
         else if (clr)                         acc_q <= '0;
         else if (upd && ptr == LPW'(l))       acc_q <= acc_q ^ din;
      end
      assign chk[l] = acc_q;
   end

   // R4: a clear empties every check lane
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (chk == '0));
endmodule

// File: rtl/rz_pulse_serializer.sv
`timescale 1ns/1ps
module rz_pulse_serializer #(
   parameter int DATA_W      = 8,
   parameter int CELL_CYCLES = 288,
   parameter int HIGH_CYCLES = 72,
   parameter int NUM_BYTES   = 402,
   parameter int CHECK_LANES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              line_out,
   output logic              busy,
   output logic              done,
   output logic              underrun
);
   import rz_pkg::*;

   localparam int TOTAL = NUM_BYTES + CHECK_LANES;
   localparam int IW    = $clog2(TOTAL + 1);
   localparam int BW    = $clog2(DATA_W);
   localparam int CW    = $clog2(CELL_CYCLES);
   localparam logic [IW-1:0] LAST_PAY = IW'(NUM_BYTES - 1);

   if (DATA_W < 2 || NUM_BYTES < 1) begin : g_bad_sizes
      $error("DATA_W must be at least 2 and NUM_BYTES at least 1");
   end

   rz_state_e          state;
   logic [DATA_W-1:0]  sh, nxt, pay_byte, chk_byte, new_byte;
   logic [BW-1:0]      bit_idx;
   logic [IW-1:0]      byte_idx, nb, lane_idx;
   logic               nxt_full, line_q, done_q, urun_q;
   logic               go, accept, first_load, boundary, pay_load, finish;
   logic               cell_last, win_last;
   logic [CW-1:0]      tm_cnt;
   logic [CHECK_LANES-1:0][DATA_W-1:0] chk;

   assign go         = (state == ST_IDLE) && start;
   assign in_ready   = !nxt_full && ((state == ST_WAIT) ||
                       ((state == ST_RUN) && (byte_idx < LAST_PAY)));
   assign accept     = in_valid && in_ready;
   assign first_load = (state == ST_WAIT) && nxt_full;
   assign boundary   = (state == ST_RUN) && cell_last && (bit_idx == '0);
   assign nb         = byte_idx + IW'(1);
   assign pay_load   = boundary && (byte_idx < LAST_PAY);
   assign finish     = boundary && (nb == IW'(TOTAL));
   assign lane_idx   = nb - IW'(NUM_BYTES);
   assign pay_byte   = nxt_full ? nxt : '0;

   always_comb begin
      chk_byte = '0;
      for (int l = 0; l < CHECK_LANES; l++)
         if (lane_idx == IW'(l)) chk_byte = chk[l];
      new_byte = pay_load ? pay_byte : chk_byte;
   end

   rz_cell_timer #(.CELL_CYCLES(CELL_CYCLES), .HIGH_CYCLES(HIGH_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(first_load), .run(state == ST_RUN),
      .cnt(tm_cnt), .cell_last(cell_last), .win_last(win_last));

   rz_check_gen #(.DATA_W(DATA_W), .LANES(CHECK_LANES)) u_check (
      .clk(clk), .rst_n(rst_n), .clr(go), .upd(first_load || pay_load),
      .din(pay_byte), .chk(chk));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sh       <= '0;
         nxt      <= '0;
         nxt_full <= 1'b0;
         bit_idx  <= '0;
         byte_idx <= '0;
         line_q   <= 1'b0;
         done_q   <= 1'b0;
         urun_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state    <= ST_WAIT;
               nxt_full <= 1'b0;
               urun_q   <= 1'b0;
            end
            ST_WAIT: if (nxt_full) begin
               state    <= ST_RUN;
               sh       <= nxt;
               nxt_full <= 1'b0;
               bit_idx  <= BW'(DATA_W - 1);
               byte_idx <= '0;
               line_q   <= nxt[DATA_W-1];
            end
            ST_RUN: if (cell_last) begin
               if (bit_idx != '0) begin
                  sh      <= {sh[DATA_W-2:0], sh[DATA_W-1]};
                  bit_idx <= bit_idx - BW'(1);
                  line_q  <= sh[DATA_W-2];
               end else if (finish) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  line_q <= 1'b0;
               end else begin
                  sh       <= new_byte;
                  bit_idx  <= BW'(DATA_W - 1);
                  byte_idx <= nb;
                  line_q   <= new_byte[DATA_W-1];
                  if (pay_load) begin
                     nxt_full <= 1'b0;
                     if (!nxt_full) urun_q <= 1'b1;
                  end
               end
            end else if (win_last) begin
               line_q <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
         if (accept) begin
            nxt      <= in_data;
            nxt_full <= 1'b1;
         end
      end
   end

   assign line_out = line_q;
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign underrun = urun_q;

   // R2: the line is only ever high inside the data window of a running cell
   p_line_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_out |-> (busy && tm_cnt < CW'(HIGH_CYCLES)));
   // R5: bytes are only taken during a transfer
   p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);
   // R6: the underrun flag holds until a new transfer opens
   p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !go) |=> underrun);
   // R7: done is a single-cycle pulse seen only once idle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R8: a start while busy cannot end the transfer
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !(cell_last && finish)) |=> busy);
endmodule

// File: tb/rz_pulse_serializer_test.sv
`timescale 1ns/1ps
module rz_pulse_serializer_test;
   localparam int CELL  = 12;
   localparam int HIGH  = 3;
   localparam int NUM   = 5;
   localparam int LANES = 2;
   localparam int TOTAL = NUM + LANES;

   logic clk = 1'b0;
   logic rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic in_ready, line_out, busy, done, underrun;

   always #2.5 clk = ~clk;

   rz_pulse_serializer #(.DATA_W(8), .CELL_CYCLES(CELL), .HIGH_CYCLES(HIGH),
      .NUM_BYTES(NUM), .CHECK_LANES(LANES)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .line_out(line_out),
      .busy(busy), .done(done), .underrun(underrun));

   int n_run = 0, n_fail = 0, cyc = 0;
   logic [7:0] pay  [NUM];
   logic [7:0] expb [TOTAL];
   bit first_acc;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   // model for R4: zero-filled payload past feed_n, then interleaved XOR lanes
   function automatic void build_expect(input int feed_n);
      for (int i = 0; i < NUM; i++) expb[i] = (i < feed_n) ? pay[i] : 8'h00;
      for (int l = 0; l < LANES; l++) expb[NUM + l] = 8'h00;
      for (int i = 0; i < NUM; i++) expb[NUM + (i % LANES)] ^= expb[i];
   endfunction

   task automatic run_xfer(input int feed_n, input int gap_max, input bit poke);
      build_expect(feed_n);
      first_acc = 1'b0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy && in_ready, "R5 busy and ready after start", {busy, in_ready}, 3);
      chk(!underrun, "R6 underrun cleared by start", underrun, 0);
      fork
         begin : feeder
            for (int i = 0; i < feed_n; i++) begin
               repeat ($urandom_range(0, gap_max)) @(negedge clk);
               while (!in_ready) @(negedge clk);
               in_valid = 1'b1;
               in_data  = pay[i];
               @(posedge clk);
               if (i == 0) first_acc = 1'b1;
               @(negedge clk);
               in_valid = 1'b0;
            end
         end
         begin : monitor
            wait (first_acc);
            @(posedge clk);
            for (int k = 0; k < TOTAL * 8; k++) begin
               logic b, bad, a_lvl, e_lvl;
               b = expb[k / 8][7 - (k % 8)];
               bad = 1'b0; a_lvl = 1'b0; e_lvl = 1'b0;
               for (int c = 0; c < CELL; c++) begin
                  int j;
                  logic e;
                  @(negedge clk);
                  j = k * CELL + c;
                  e = b && (c < HIGH);
                  if (line_out !== e && !bad) begin
                     bad = 1'b1; a_lvl = line_out; e_lvl = e;
                  end
                  if (feed_n < NUM && (j == feed_n * 8 * CELL - 1 || j == feed_n * 8 * CELL))
                     chk(underrun == (j >= feed_n * 8 * CELL), "R6 underrun edge at empty slot",
                         underrun, (j >= feed_n * 8 * CELL));
               end
               if (k < NUM * 8)
                  chk(!bad, $sformatf("R1 R2 R3 payload cell %0d", k), a_lvl, e_lvl);
               else
                  chk(!bad, $sformatf("R4 check cell %0d", k), a_lvl, e_lvl);
            end
            chk(busy && !done, "R7 still busy in last cell", {busy, done}, 2);
            @(negedge clk);
            chk(done && !busy, "R7 done with busy low after last cell", {busy, done}, 1);
            @(negedge clk);
            chk(!done, "R7 done lasts one cycle", done, 0);
         end
         begin : poker
            if (poke) begin
               repeat (40) @(negedge clk);
               start = 1'b1;
               @(negedge clk);
               start = 1'b0;
               chk(busy, "R8 start while busy ignored", busy, 1);
            end
         end
      join
      chk(underrun == (feed_n < NUM), "R6 underrun sticky at end", underrun, (feed_n < NUM));
      chk(!in_ready, "R5 ready low when idle", in_ready, 0);
   endtask

   initial begin
      void'($urandom(32'd20240512));
      repeat (3) @(negedge clk);
      chk(!line_out && !busy && !done && !in_ready && !underrun, "R9 outputs during reset",
          {line_out, busy, done, in_ready, underrun}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!line_out && !busy && !done && !in_ready && !underrun, "R9 outputs after reset",
          {line_out, busy, done, in_ready, underrun}, 0);

      // directed: mixed patterns, back-to-back feeding
      pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'hFF; pay[3] = 8'h00; pay[4] = 8'h81;
      run_xfer(NUM, 0, 1'b0);
      // directed: single-bit patterns checking bit order, with start poke
      pay[0] = 8'h80; pay[1] = 8'h01; pay[2] = 8'h40; pay[3] = 8'h02; pay[4] = 8'h55;
      run_xfer(NUM, 20, 1'b1);
      // random payloads and feed gaps
      for (int t = 0; t < 4; t++) begin
         for (int i = 0; i < NUM; i++) pay[i] = 8'($urandom);
         run_xfer(NUM, 25, t[0]);
      end
      // forced underrun: only two bytes supplied
      for (int i = 0; i < NUM; i++) pay[i] = 8'($urandom);
      run_xfer(2, 5, 1'b0);
      // full transfer after underrun clears the flag
      for (int i = 0; i < NUM; i++) pay[i] = 8'($urandom);
      run_xfer(NUM, 10, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule